// File: doc/BRIEF.md
# Paging Address Translator with Tagged Lookup Buffer

This block turns a logical address from a processor into a physical address. The logical address is split into a page number (upper bits) and an in-page offset (lower bits). The page number is searched in a small fully associative lookup buffer. Each buffer entry is tagged with an address-space identifier, so translations that belong to different processes can sit in the buffer together. When the buffer holds the page, the unit places the stored frame number above the unchanged offset and completes in the same cycle as the request.

When the buffer does not hold the page, the unit issues one read of a page-table entry from memory. The read address is the table base plus the page number. The unit checks the entry that comes back, loads it into the buffer and then completes. A page number that lies beyond the table length faults at once, without any memory read. An entry without its valid flag faults. A write to a page marked read-only faults. A flush input empties the buffer in one cycle. The requester holds `req_valid` only while `rdy` is high. While a miss is outstanding, `rdy` stays low.

Top module: `xlat_unit`

## Requirements
- R1: The physical address on `pa_out` is the frame number concatenated above the low `OFF_W` bits of the logical address. The offset bits pass through unchanged. With the defaults, logical address 8'h0A (page 2, offset 2), where page 2 maps to frame 7, gives 5'd30.
- R2: A request that hits in the buffer raises `done` in the same cycle as `req_valid`. `rdy` stays high and no memory read is issued.
- R3: A buffer hit needs both the page number and `req_asid` to match a valid entry. The same page under another identifier misses.
- R4: On a miss, exactly one read is issued, with `mem_rd_en` high in the request cycle and `mem_rd_addr` = `ptbr` + page number. `rdy` stays low until `mem_rd_valid`, and `done` rises in the cycle of that response.
- R5: Page-table entry format: bit `FRAME_W+1` is the valid flag, bit `FRAME_W` is the read-only flag, and the low `FRAME_W` bits are the frame. A returned entry with the valid flag set is written into the buffer, even when the access itself faults on protection. Entries without the valid flag are never stored.
- R6: If the page number is greater than or equal to `ptlr`, the request completes in its own cycle with `fault`=1 and `fault_kind`=1. No memory read is made, and this check comes before the buffer lookup.
- R7: A returned entry without the valid flag completes with `fault`=1 and `fault_kind`=2. A completion without a fault reports `fault_kind`=0 and `fault`=0.
- R8: A write (`req_wr`=1) to a read-only page completes with `fault`=1 and `fault_kind`=3, on both the hit path and the miss path. Reads of read-only pages succeed. When there is a fault, `pa_out` is zero.
- R9: `flush` clears every buffer entry in one cycle and sets the replacement pointer to entry 0.
- R10: Refills use round-robin placement over the `TLB_N` entries, starting at entry 0 after reset or flush. With 8 entries, the ninth distinct refill evicts the first page loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request, taken while rdy is high |
| req_wr | input | 1 | Request is a write |
| req_laddr | input | LA_W | Logical address |
| req_asid | input | ASID_W | Current address-space identifier |
| ptbr | input | MEM_AW | Page-table base address |
| ptlr | input | LA_W-OFF_W+1 | Page-table length in entries |
| rdy | output | 1 | Unit idle and able to take a request |
| done | output | 1 | Translation complete this cycle |
| pa_out | output | FRAME_W+OFF_W | Physical address |
| fault | output | 1 | Completion is a fault |
| fault_kind | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |
| mem_rd_en | output | 1 | Page-table read request |
| mem_rd_addr | output | MEM_AW | Page-table read address |
| mem_rd_valid | input | 1 | Page-table read data present |
| mem_rd_data | input | FRAME_W+2 | Page-table entry |

## Verification
The assertions assume that the memory side returns `mem_rd_valid` only while a read is outstanding (`rdy` low), and exactly once for each read. They also assume that `req_valid` is raised only while `rdy` is high. The bench memory model answers each read a fixed two cycles after it is accepted and never otherwise. The driver raises a request only after it has seen `rdy` high, and holds it for a single cycle. Identifier, base and length inputs may change between requests, because the unit latches what a miss needs.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_LEN  = 2'd1,
        FLT_INV  = 2'd2,
        FLT_PROT = 2'd3
    } flt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int TLB_N   = 8,
    parameter int PN_W    = 6,
    parameter int FRAME_W = 3,
    parameter int ASID_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PN_W-1:0]    lk_page,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_frame,
    output logic               hit_ro,
    input  logic               fill_en,
    input  logic [PN_W-1:0]    fill_page,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_ro
);
    localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

    typedef struct packed {
        logic               v;
        logic [PN_W-1:0]    pn;
        logic [ASID_W-1:0]  asid;
        logic [FRAME_W-1:0] fr;
        logic               ro;
    } ent_t;

    typedef struct packed {
        ent_t [TLB_N-1:0] ent;
        logic [PTR_W-1:0] ptr;
    } tlb_t;

    tlb_t s_q, s_d;
    logic [TLB_N-1:0] match;

    for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
        assign match[g] = s_q.ent[g].v && (s_q.ent[g].pn == lk_page)
                          && (s_q.ent[g].asid == lk_asid);
    end

    always_comb begin
        hit       = 1'b0;
        hit_frame = '0;
        hit_ro    = 1'b0;
        for (int i = 0; i < TLB_N; i++) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_frame = hit_frame | s_q.ent[i].fr;
                hit_ro    = hit_ro | s_q.ent[i].ro;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            for (int i = 0; i < TLB_N; i++) begin
                s_d.ent[i].v = 1'b0;
            end
            s_d.ptr = '0;
        end else if (fill_en) begin
            s_d.ent[s_q.ptr] = '{v: 1'b1, pn: fill_page, asid: fill_asid,
                                 fr: fill_frame, ro: fill_ro};
            s_d.ptr = (s_q.ptr == PTR_W'(TLB_N - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/xlat_pte_check.sv
module xlat_pte_check (
    input  logic             ent_valid,
    input  logic             ent_ro,
    input  logic             is_write,
    output xlat_pkg::flt_e   kind
);
    import xlat_pkg::*;

    always_comb begin
        if (!ent_valid) begin
            kind = FLT_INV;
        end else if (ent_ro && is_write) begin
            kind = FLT_PROT;
        end else begin
            kind = FLT_NONE;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
    parameter int LA_W    = 8,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3,
    parameter int ASID_W  = 4,
    parameter int MEM_AW  = 8,
    parameter int TLB_N   = 8,
    localparam int PN_W   = LA_W - OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W,
    localparam int PTE_W  = FRAME_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [LA_W-1:0]   req_laddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [MEM_AW-1:0] ptbr,
    input  logic [PN_W:0]     ptlr,
    output logic              rdy,
    output logic              done,
    output logic [PA_W-1:0]   pa_out,
    output logic              fault,
    output logic [1:0]        fault_kind,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data
);
    import xlat_pkg::*;

    typedef struct packed {
        st_e               st;
        logic [PN_W-1:0]   pn;
        logic [OFF_W-1:0]  off;
        logic              wr;
        logic [ASID_W-1:0] asid;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [PN_W-1:0]    in_pn;
    logic [OFF_W-1:0]   in_off;
    logic               len_bad;
    logic               hit;
    logic [FRAME_W-1:0] hit_frame;
    logic               hit_ro;
    logic               pte_v;
    logic               pte_ro;
    logic [FRAME_W-1:0] pte_fr;
    logic               chk_v;
    logic               chk_ro;
    logic               chk_wr;
    flt_e               chk_kind;
    logic               fill_en;

    assign in_pn   = req_laddr[LA_W-1:OFF_W];
    assign in_off  = req_laddr[OFF_W-1:0];
    assign len_bad = {1'b0, in_pn} >= ptlr;
    assign pte_v   = mem_rd_data[FRAME_W+1];
    assign pte_ro  = mem_rd_data[FRAME_W];
    assign pte_fr  = mem_rd_data[FRAME_W-1:0];

    // The checker sees the buffer entry while idle and the fetched entry while waiting.
    assign chk_v  = (c_q.st == ST_IDLE) ? 1'b1   : pte_v;
    assign chk_ro = (c_q.st == ST_IDLE) ? hit_ro : pte_ro;
    assign chk_wr = (c_q.st == ST_IDLE) ? req_wr : c_q.wr;

    xlat_tlb #(
        .TLB_N  (TLB_N),
        .PN_W   (PN_W),
        .FRAME_W(FRAME_W),
        .ASID_W (ASID_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_page   (in_pn),
        .lk_asid   (req_asid),
        .hit       (hit),
        .hit_frame (hit_frame),
        .hit_ro    (hit_ro),
        .fill_en   (fill_en),
        .fill_page (c_q.pn),
        .fill_asid (c_q.asid),
        .fill_frame(pte_fr),
        .fill_ro   (pte_ro)
    );

    xlat_pte_check u_chk_pte (
        .ent_valid(chk_v),
        .ent_ro   (chk_ro),
        .is_write (chk_wr),
        .kind     (chk_kind)
    );

    always_comb begin
        c_d         = c_q;
        rdy         = (c_q.st == ST_IDLE);
        done        = 1'b0;
        fault       = 1'b0;
        fault_kind  = FLT_NONE;
        pa_out      = '0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = ptbr + MEM_AW'(in_pn);
        fill_en     = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (len_bad) begin
                        done       = 1'b1;
                        fault      = 1'b1;
                        fault_kind = FLT_LEN;
                    end else if (hit) begin
                        done       = 1'b1;
                        fault_kind = chk_kind;
                        fault      = (chk_kind != FLT_NONE);
                        pa_out     = fault ? '0 : {hit_frame, in_off};
                    end else begin
                        mem_rd_en = 1'b1;
                        c_d.st    = ST_WAIT;
                        c_d.pn    = in_pn;
                        c_d.off   = in_off;
                        c_d.wr    = req_wr;
                        c_d.asid  = req_asid;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    done       = 1'b1;
                    fault_kind = chk_kind;
                    fault      = (chk_kind != FLT_NONE);
                    pa_out     = fault ? '0 : {pte_fr, c_q.off};
                    fill_en    = pte_v;
                    c_d.st     = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
    parameter int LA_W    = 8,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [LA_W-1:0]          req_laddr,
    input logic [LA_W-OFF_W:0]      ptlr,
    input logic                     rdy,
    input logic                     done,
    input logic [FRAME_W+OFF_W-1:0] pa_out,
    input logic                     fault,
    input logic [1:0]               fault_kind,
    input logic                     mem_rd_en,
    input logic                     mem_rd_valid
);
    logic page_over;
    assign page_over = {1'b0, req_laddr[LA_W-1:OFF_W]} >= ptlr;

    AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && req_valid && page_over) |-> (done && fault && fault_kind == 2'd1 && !mem_rd_en)); // R6
    AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (rdy && req_valid && !page_over)); // R4
    AST_MISS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !rdy); // R4
    AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !mem_rd_valid) |-> !done); // R4
    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy) |-> !mem_rd_en); // R2
    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy && !fault) |-> (pa_out[OFF_W-1:0] == req_laddr[OFF_W-1:0])); // R1
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_kind != 2'd0))); // R7
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa_out == '0)); // R8
endmodule

bind xlat_unit xlat_unit_chk #(
    .LA_W   (LA_W),
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W)
) u_xlat_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_laddr   (req_laddr),
    .ptlr        (ptlr),
    .rdy         (rdy),
    .done        (done),
    .pa_out      (pa_out),
    .fault       (fault),
    .fault_kind  (fault_kind),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_valid(mem_rd_valid)
);

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] BASE = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_wr = 1'b0;
    logic [7:0] req_laddr = '0;
    logic [3:0] req_asid = '0;
    logic [7:0] ptbr = BASE;
    logic [6:0] ptlr = 7'd16;
    logic       rdy;
    logic       done;
    logic [4:0] pa_out;
    logic       fault;
    logic [1:0] fault_kind;
    logic       mem_rd_en;
    logic [7:0] mem_rd_addr;
    logic       mem_rd_valid = 1'b0;
    logic [4:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;

    logic [9:0] expq[$];
    string      tagq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_wr(req_wr), .req_laddr(req_laddr), .req_asid(req_asid),
        .ptbr(ptbr), .ptlr(ptlr), .rdy(rdy), .done(done), .pa_out(pa_out),
        .fault(fault), .fault_kind(fault_kind), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data)
    );

    // Entry format {valid, read_only, frame[2:0]}
    function automatic logic [4:0] pte_of(int p);
        if (p == 2) return {2'b10, 3'd7};
        if (p == 3) return {2'b11, 3'd5};
        if (p == 4) return {2'b11, 3'd1};
        if (p == 5) return 5'b0;
        if (p >= 0 && p < 16) return {2'b10, 3'(p)};
        return 5'b0;
    endfunction

    // Memory model: answers two cycles after the read is taken
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_en) begin
                logic [7:0] a;
                a = mem_rd_addr;
                @(posedge clk);
                repeat (2) @(posedge clk);
                #1;
                mem_rd_valid = 1'b1;
                mem_rd_data  = pte_of(int'(a) - int'(BASE));
                @(posedge clk);
                #1;
                mem_rd_valid = 1'b0;
            end
        end
    end

    // Expected word: {rdy_at_done, mem_rd_en, fault, kind[1:0], pa[4:0]}
    task automatic req(input logic [7:0] a, input logic wr, input logic [3:0] as,
                       input logic ehit, input string tag);
        logic [5:0] p;
        logic [4:0] e;
        logic [9:0] w;
        p = a[7:2];
        e = pte_of(int'(p));
        if ({1'b0, p} >= ptlr)      w = {1'b1, 1'b0, 1'b1, 2'd1, 5'd0};
        else if (!e[4])             w = {ehit, 1'b0, 1'b1, 2'd2, 5'd0};
        else if (e[3] && wr)        w = {ehit, 1'b0, 1'b1, 2'd3, 5'd0};
        else                        w = {ehit, 1'b0, 1'b0, 2'd0, e[2:0], a[1:0]};
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_wr    = wr;
        req_laddr = a;
        req_asid  = as;
        expq.push_back(w);
        tagq.push_back(tag);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        while (!rdy) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_flush();
        @(posedge clk);
        #1;
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            logic [9:0] got;
            got = {rdy, mem_rd_en, fault, fault_kind, pa_out};
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL unexpected completion: got %b expected none", got);
            end else begin
                logic [9:0] w;
                string t;
                w = expq.pop_front();
                t = tagq.pop_front();
                if (got !== w) begin
                    errors++;
                    $display("FAIL %s: got {rdy,rd,fault,kind,pa}=%b expected %b", t, got, w);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({rdy, done, mem_rd_en} !== 3'b100) begin
            errors++;
            $display("FAIL R2 reset state: got %b expected 100", {rdy, done, mem_rd_en});
        end

        req(8'h0A, 1'b0, 4'd1, 1'b0, "R1 R4 miss page2 -> 30");
        req(8'h0A, 1'b0, 4'd1, 1'b1, "R2 hit page2 -> 30");
        req(8'h0B, 1'b1, 4'd1, 1'b1, "R2 R8 write hit rw page");
        req(8'h0A, 1'b0, 4'd2, 1'b0, "R3 other identifier misses");
        req(8'h0A, 1'b0, 4'd2, 1'b1, "R3 other identifier now hits");
        req(8'h0D, 1'b0, 4'd1, 1'b0, "R8 read of read-only page");
        req(8'h0D, 1'b1, 4'd1, 1'b1, "R8 write hit read-only faults");
        req(8'h12, 1'b1, 4'd1, 1'b0, "R8 write miss read-only faults");
        req(8'h12, 1'b0, 4'd1, 1'b1, "R5 filled despite protection fault");
        req(8'h14, 1'b0, 4'd1, 1'b0, "R7 invalid entry faults");
        req(8'h14, 1'b0, 4'd1, 1'b0, "R5 R7 invalid entry not stored");
        req(8'h40, 1'b0, 4'd1, 1'b1, "R6 page at length faults");
        req(8'hFF, 1'b1, 4'd1, 1'b1, "R6 top page faults");
        req(8'h3C, 1'b0, 4'd1, 1'b0, "R6 last page inside length");
        ptlr = 7'd2;
        req(8'h0A, 1'b0, 4'd1, 1'b1, "R6 length before buffer");
        ptlr = 7'd16;
        do_flush();
        req(8'h0A, 1'b0, 4'd1, 1'b0, "R9 flush forces miss");
        do_flush();
        for (int p = 6; p <= 13; p++) begin
            req(8'(p << 2), 1'b0, 4'd1, 1'b0, "R10 fill");
        end
        req(8'h1B, 1'b0, 4'd1, 1'b1, "R10 page6 still held");
        req(8'(14 << 2), 1'b0, 4'd1, 1'b0, "R10 ninth refill");
        req(8'(7 << 2), 1'b0, 4'd1, 1'b1, "R10 page7 kept");
        req(8'(13 << 2), 1'b0, 4'd1, 1'b1, "R10 page13 kept");
        req(8'(6 << 2), 1'b0, 4'd1, 1'b0, "R10 page6 evicted");
        req(8'(7 << 2), 1'b0, 4'd1, 1'b0, "R9 R10 page7 evicted next");

        repeat (4) @(posedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R4 missing completions: got %0d pending expected 0", expq.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule